// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This engine lets a host copy configuration item data into system memory, or skip over it, with a single register write. The host places a 16-byte descriptor in memory and writes its physical address into a 64-bit big-endian address register. The register is written as two 32-bit halves. Writing the upper half only stores bits. Writing the lower half launches the operation.

The engine reads the descriptor as four 32-bit words and converts each word from big-endian to native order. If the descriptor asks for it, the engine applies a new item key through the selector link. It then copies the requested bytes one at a time to the target address, or advances the item offset without touching memory. Finally it reports the outcome by rewriting the descriptor's control word in place. The memory side is a simple master with separate read and write request/acknowledge handshakes.

The controller has six states:
- `S_IDLE` waits for a start.
- `S_FETCH` reads the four descriptor words.
- `S_SELECT` applies the key.
- `S_SETTLE` gives the selector one cycle and then decides.
- `S_COPY` writes data bytes.
- `S_STATUS` writes the status word.

The transitions are:
- `S_IDLE` to `S_FETCH` on start.
- `S_FETCH` to `S_SELECT` on the fourth read acknowledge.
- `S_SELECT` to `S_SETTLE` unconditionally.
- `S_SETTLE` to `S_COPY` for a valid, non-empty read.
- `S_SETTLE` to `S_STATUS` for an error, a skip, an empty read or a no-op.
- `S_COPY` to `S_STATUS` on the last byte acknowledge.
- `S_STATUS` to `S_IDLE` on the write acknowledge.

Top module: `cfgdma_engine`

## Requirements
- R1: After reset `busy` is low, no memory request, `sel_wr` or `item_adv` is active, and the whole 64-bit address register is zero.
- R2: A register write with `reg_wr_lo`=0 stores the upper 32 address bits and starts nothing. `busy` stays low and no memory read is issued.
- R3: A write with `reg_wr_lo`=1 stores the lower 32 bits and starts an operation. The engine issues four 32-bit reads at the descriptor address plus 0, 4, 8 and 12, one at a time. On the data buses, byte lane k (bits 8k+7:8k) is the byte at address+k. Words are big-endian: word 0 is control, word 1 is length, words 2 and 3 are the upper and lower halves of the target address.
- R4: If control bit 3 is set, `sel_wr` pulses once with `sel_key` equal to control bits 31:16, before any data byte is written.
- R5: If control bit 1 is set and the read is valid, byte i of the item is written to target+i for i from 0 to length-1. Each write uses `mem_wr_be`=0001 with the byte in lane 0. Each accepted byte gives one `item_adv` pulse with `item_adv_len`=1. A length of 0 writes nothing.
- R6: If control bit 2 is set and bit 1 is clear, no data is written, and a single `item_adv` pulse carries the length (none when the length is 0).
- R7: Completion writes a full word (`mem_wr_be`=1111) at the descriptor address. The data is 0 on success. On error it is 32'h0100_0000, which is a native value of 1, so control bit 0 is set.
- R8: A read whose item is not valid (`item_ok`=0), or whose length exceeds `item_remain`, writes no data, advances nothing and reports error.
- R9: Register writes of either half while `busy` is high are ignored. They neither start a second operation nor change the stored address.
- R10: The address register returns to zero when an operation completes, so a later lower-half write alone starts from a descriptor below 4 GiB.
- R11: `busy` stays high from the cycle after the launching write until the status write has been acknowledged.
- R12: A memory read or write request stays asserted with stable address and byte enables until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Address register write strobe |
| reg_wr_lo | input | 1 | 1: lower half (offset 4, launches); 0: upper half (offset 0) |
| reg_wr_data | input | 32 | Write data, byte lane k at offset+k |
| busy | output | 1 | Operation in progress |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 64 | Read byte address |
| mem_rd_ack | input | 1 | Read accepted, data valid |
| mem_rd_data | input | 32 | Read data, lane k = address+k |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | 64 | Write byte address |
| mem_wr_data | output | 32 | Write data, lane k = address+k |
| mem_wr_be | output | 4 | Byte-lane enables |
| mem_wr_ack | input | 1 | Write accepted |
| sel_wr | output | 1 | Apply a new item key |
| sel_key | output | 16 | Item key |
| item_ok | input | 1 | Current key names a valid item |
| item_remain | input | 32 | Bytes left from the current offset |
| item_byte | input | 8 | Item byte at the current offset |
| item_adv | output | 1 | Advance the item offset |
| item_adv_len | output | 32 | Advance amount in bytes |

## Verification
The assertions rely on some properties of the environment:
- The memory raises an acknowledge only while the matching request is pending.
- Read data is valid in the acknowledge cycle.
- The selector updates `item_ok`, `item_remain` and `item_byte` one cycle after a `sel_wr` or `item_adv` pulse.

The bench respects these properties. Its memory model registers each acknowledge only against a pending request and applies a programmable latency of zero to two cycles. Its selector model registers key and offset and derives its outputs from them.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_SELECT,
        S_SETTLE,
        S_COPY,
        S_STATUS
    } cfgdma_state_t;

    localparam int CTL_READ = 1;
    localparam int CTL_SKIP = 2;
    localparam int CTL_SEL  = 3;
endpackage

// File: rtl/cfgdma_bswap.sv
module cfgdma_bswap #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign dout[8*i +: 8] = din[8*(BYTES-1-i) +: 8];
    end
endmodule

// File: rtl/cfgdma_addr_reg.sv
module cfgdma_addr_reg #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_lo,
    input  logic [ADDR_W/2-1:0] wr_data,
    input  logic              accept,
    input  logic              clear,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int HALF_W = ADDR_W / 2;

    logic [HALF_W-1:0] native;
    logic [ADDR_W-1:0] addr_q;

    cfgdma_bswap #(.BYTES(HALF_W / 8)) u_swap (
        .din  (wr_data),
        .dout (native)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            start  <= 1'b0;
        end else begin
            start <= 1'b0;
            if (clear) begin
                addr_q <= '0;
            end else if (wr_en && accept) begin
                if (wr_lo) begin
                    addr_q[HALF_W-1:0] <= native;
                    start              <= 1'b1;
                end else begin
                    addr_q[ADDR_W-1:HALF_W] <= native;
                end
            end
        end
    end

    assign start_addr = addr_q;
endmodule

// File: rtl/cfgdma_desc_regs.sv
module cfgdma_desc_regs #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 32,
    parameter int KEY_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic [1:0]          cap_idx,
    input  logic [WORD_W-1:0]   cap_word,
    output logic [3:0]          ctl_flags,
    output logic [KEY_W-1:0]    key,
    output logic [LEN_W-1:0]    len,
    output logic [2*WORD_W-1:0] target
);
    logic [WORD_W-1:0] word;

    cfgdma_bswap #(.BYTES(WORD_W / 8)) u_swap (
        .din  (cap_word),
        .dout (word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_flags <= '0;
            key       <= '0;
            len       <= '0;
            target    <= '0;
        end else if (cap_en) begin
            unique case (cap_idx)
                2'd0: begin
                    ctl_flags <= word[3:0];
                    key       <= word[WORD_W-1 -: KEY_W];
                end
                2'd1: len <= word[LEN_W-1:0];
                2'd2: target[2*WORD_W-1:WORD_W] <= word;
                2'd3: target[WORD_W-1:0] <= word;
            endcase
        end
    end
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
    import cfgdma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 32,
    parameter int KEY_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic                reg_wr_lo,
    input  logic [WORD_W-1:0]   reg_wr_data,
    output logic                busy,
    output logic                mem_rd_req,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic                mem_rd_ack,
    input  logic [WORD_W-1:0]   mem_rd_data,
    output logic                mem_wr_req,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [WORD_W-1:0]   mem_wr_data,
    output logic [WORD_W/8-1:0] mem_wr_be,
    input  logic                mem_wr_ack,
    output logic                sel_wr,
    output logic [KEY_W-1:0]    sel_key,
    input  logic                item_ok,
    input  logic [LEN_W-1:0]    item_remain,
    input  logic [7:0]          item_byte,
    output logic                item_adv,
    output logic [LEN_W-1:0]    item_adv_len
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam logic [WORD_W-1:0] ERR_WORD = {8'h01, {(WORD_W-8){1'b0}}};

    cfgdma_state_t state, state_nx;

    logic              start;
    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] desc_base;
    logic [1:0]        widx;
    logic [LEN_W-1:0]  cnt;
    logic              err;
    logic [3:0]        ctl_flags;
    logic [LEN_W-1:0]  len;
    logic [2*WORD_W-1:0] target;
    logic              rd_bad;
    logic              clear;

    cfgdma_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_lo      (reg_wr_lo),
        .wr_data    (reg_wr_data),
        .accept     (!busy),
        .clear      (clear),
        .start      (start),
        .start_addr (start_addr)
    );

    cfgdma_desc_regs #(.WORD_W(WORD_W), .LEN_W(LEN_W), .KEY_W(KEY_W)) u_desc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (state == S_FETCH && mem_rd_ack),
        .cap_idx   (widx),
        .cap_word  (mem_rd_data),
        .ctl_flags (ctl_flags),
        .key       (sel_key),
        .len       (len),
        .target    (target)
    );

    assign busy   = (state != S_IDLE) || start;
    assign clear  = (state == S_STATUS) && mem_wr_ack;
    assign rd_bad = ctl_flags[CTL_READ] && (!item_ok || (len > item_remain));
    assign mem_rd_addr = desc_base + ADDR_W'({widx, 2'b00});

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_base <= '0;
            widx      <= '0;
            cnt       <= '0;
            err       <= 1'b0;
        end else begin
            if (state == S_IDLE && start) begin
                desc_base <= start_addr;
                widx      <= '0;
                cnt       <= '0;
                err       <= 1'b0;
            end
            if (state == S_FETCH && mem_rd_ack) widx <= widx + 2'd1;
            if (state == S_SETTLE && rd_bad)    err  <= 1'b1;
            if (state == S_COPY && mem_wr_ack)  cnt  <= cnt + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_FETCH;
            S_FETCH:  if (mem_rd_ack && widx == 2'd3) state_nx = S_SELECT;
            S_SELECT: state_nx = S_SETTLE;
            S_SETTLE: begin
                if (ctl_flags[CTL_READ] && !rd_bad && len != '0) state_nx = S_COPY;
                else                                              state_nx = S_STATUS;
            end
            S_COPY:   if (mem_wr_ack && cnt == len - 1'b1) state_nx = S_STATUS;
            S_STATUS: if (mem_wr_ack) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_rd_req   = 1'b0;
        mem_wr_req   = 1'b0;
        mem_wr_addr  = desc_base;
        mem_wr_data  = '0;
        mem_wr_be    = '0;
        sel_wr       = 1'b0;
        item_adv     = 1'b0;
        item_adv_len = '0;
        unique case (state)
            S_IDLE:   ;
            S_FETCH:  mem_rd_req = 1'b1;
            S_SELECT: sel_wr = ctl_flags[CTL_SEL];
            S_SETTLE: begin
                if (!ctl_flags[CTL_READ] && ctl_flags[CTL_SKIP] && len != '0) begin
                    item_adv     = 1'b1;
                    item_adv_len = len;
                end
            end
            S_COPY: begin
                mem_wr_req   = 1'b1;
                mem_wr_addr  = target + ADDR_W'(cnt);
                mem_wr_data  = {{(WORD_W-8){1'b0}}, item_byte};
                mem_wr_be    = WORD_BYTES'(1);
                item_adv     = mem_wr_ack;
                item_adv_len = LEN_W'(1);
            end
            S_STATUS: begin
                mem_wr_req  = 1'b1;
                mem_wr_addr = desc_base;
                mem_wr_data = err ? ERR_WORD : '0;
                mem_wr_be   = '1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfgdma_engine_chk.sv
module cfgdma_engine_chk #(
    parameter int ADDR_W = 64,
    parameter int WORD_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                mem_rd_req,
    input logic                mem_rd_ack,
    input logic [ADDR_W-1:0]   mem_rd_addr,
    input logic                mem_wr_req,
    input logic                mem_wr_ack,
    input logic [ADDR_W-1:0]   mem_wr_addr,
    input logic [WORD_W-1:0]   mem_wr_data,
    input logic [WORD_W/8-1:0] mem_wr_be,
    input logic                sel_wr,
    input logic                item_adv
);
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr)); // R12

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req && !mem_wr_ack |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_be)); // R12

    AST_ONE_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_req && !mem_wr_req && !item_adv && !sel_wr); // R1

    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(mem_wr_ack) && $past(mem_wr_be) == '1); // R11

    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> mem_wr_be == '1 || $onehot0(mem_wr_be) && mem_wr_be[0]); // R5

    AST_STATUS_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req && mem_wr_be == '1 |-> mem_wr_data == '0 || mem_wr_data == {8'h01, {(WORD_W-8){1'b0}}}); // R7
endmodule

bind cfgdma_engine cfgdma_engine_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_req  (mem_wr_req),
    .mem_wr_ack  (mem_wr_ack),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .mem_wr_be   (mem_wr_be),
    .sel_wr      (sel_wr),
    .item_adv    (item_adv)
);

// File: tb/cfgdma_engine_bench.sv
module cfgdma_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_lo = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        busy;
    logic        mem_rd_req;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_req;
    logic [63:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic [3:0]  mem_wr_be;
    logic        mem_wr_ack = 1'b0;
    logic        sel_wr;
    logic [15:0] sel_key;
    logic        item_ok;
    logic [31:0] item_remain;
    logic [7:0]  item_byte;
    logic        item_adv;
    logic [31:0] item_adv_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgdma_engine u_cfgdma_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_lo(reg_wr_lo), .reg_wr_data(reg_wr_data),
        .busy(busy),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_be(mem_wr_be), .mem_wr_ack(mem_wr_ack),
        .sel_wr(sel_wr), .sel_key(sel_key),
        .item_ok(item_ok), .item_remain(item_remain), .item_byte(item_byte),
        .item_adv(item_adv), .item_adv_len(item_adv_len)
    );

    int n_checks = 0;
    int n_fail = 0;

    // ---------------- memory model ----------------
    logic [7:0] mem [logic [63:0]];
    int lat = 0;
    int rd_wait = 0, wr_wait = 0;
    int rd_n = 0, data_wr_n = 0;
    logic [63:0] first_rd_addr = '0;
    logic        rd_seen = 1'b0;
    logic        order_bad = 1'b0;
    int sel_n = 0, adv_n = 0, adv_sum = 0;

    function automatic logic [7:0] peek(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        mem_rd_ack <= 1'b0;
        if (mem_rd_req && !mem_rd_ack) begin
            if (rd_wait >= lat) begin
                mem_rd_ack <= 1'b1;
                for (int k = 0; k < 4; k++) mem_rd_data[8*k +: 8] <= peek(mem_rd_addr + 64'(k));
                if (!rd_seen) begin
                    first_rd_addr <= mem_rd_addr;
                    rd_seen <= 1'b1;
                end
                rd_n <= rd_n + 1;
                rd_wait <= 0;
            end else rd_wait <= rd_wait + 1;
        end
        mem_wr_ack <= 1'b0;
        if (mem_wr_req && !mem_wr_ack) begin
            if (wr_wait >= lat) begin
                mem_wr_ack <= 1'b1;
                for (int k = 0; k < 4; k++)
                    if (mem_wr_be[k]) mem[mem_wr_addr + 64'(k)] = mem_wr_data[8*k +: 8];
                if (mem_wr_be == 4'b0001) begin
                    data_wr_n <= data_wr_n + 1;
                    if (sel_n == 0) order_bad <= 1'b1;
                end
                wr_wait <= 0;
            end else wr_wait <= wr_wait + 1;
        end
    end

    // ---------------- selector model ----------------
    logic [15:0] cur_key = 16'hFFFF;
    logic [31:0] cur_off = '0;
    logic [31:0] cur_len;

    always @(posedge clk) begin
        if (sel_wr) begin
            cur_key <= sel_key;
            cur_off <= '0;
            sel_n   <= sel_n + 1;
        end else if (item_adv) begin
            cur_off <= cur_off + item_adv_len;
            adv_n   <= adv_n + 1;
            adv_sum <= adv_sum + int'(item_adv_len);
        end
    end

    always_comb begin
        cur_len = (cur_key == 16'd5) ? 32'd8 : (cur_key == 16'd7) ? 32'd3 : 32'd0;
        item_ok = (cur_key == 16'd5) || (cur_key == 16'd7);
        item_remain = (cur_off < cur_len) ? cur_len - cur_off : '0;
        item_byte = (cur_key == 16'd5) ? 8'hA0 + cur_off[7:0] : 8'h70 + cur_off[7:0];
    end

    // ---------------- protocol monitor ----------------
    int hold_viol = 0, busy_viol = 0;
    logic p_rd_pend = 0, p_wr_pend = 0, p_busy = 0, p_stat_acc = 0;
    logic [63:0] p_rd_addr = '0, p_wr_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_rd_pend && (!mem_rd_req || mem_rd_addr != p_rd_addr)) hold_viol++;
            if (p_wr_pend && (!mem_wr_req || mem_wr_addr != p_wr_addr)) hold_viol++;
            if (p_busy && !busy && !p_stat_acc) busy_viol++;
            if (mem_wr_req && mem_wr_be == 4'hF && !busy) busy_viol++;
        end
        p_rd_pend  = mem_rd_req && !mem_rd_ack;
        p_wr_pend  = mem_wr_req && !mem_wr_ack;
        p_rd_addr  = mem_rd_addr;
        p_wr_addr  = mem_wr_addr;
        p_busy     = busy;
        p_stat_acc = mem_wr_req && mem_wr_ack && mem_wr_be == 4'hF;
    end

    // ---------------- helpers ----------------
    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic put_be32(input logic [63:0] a, input logic [31:0] v);
        mem[a]   = v[31:24];
        mem[a+1] = v[23:16];
        mem[a+2] = v[15:8];
        mem[a+3] = v[7:0];
    endtask

    task automatic put_desc(input logic [63:0] a, input logic [31:0] ctl,
                            input logic [31:0] len, input logic [63:0] tgt);
        put_be32(a, ctl);
        put_be32(a + 4, len);
        put_be32(a + 8, tgt[63:32]);
        put_be32(a + 12, tgt[31:0]);
    endtask

    function automatic logic [31:0] get_be32(input logic [63:0] a);
        return {peek(a), peek(a+1), peek(a+2), peek(a+3)};
    endfunction

    task automatic reg_write(input logic lo, input logic [31:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_lo = lo;
        reg_wr_data = swap32(val);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!busy && t < 20) begin @(negedge clk); t++; end
        t = 0;
        while (busy && t < 3000) begin @(negedge clk); t++; end
        check(!busy, req, 64'(busy), 64'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(busy == 1'b0, "R1 busy", 64'(busy), 0);
        check(!mem_rd_req && !mem_wr_req, "R1 requests", 64'({mem_rd_req, mem_wr_req}), 0);
    endtask

    task automatic t_upper_only();
        int r0 = rd_n;
        reg_write(1'b0, 32'h0000_0001);
        repeat (6) @(negedge clk);
        check(!busy, "R2 busy", 64'(busy), 0);
        check(rd_n == r0, "R2 reads", 64'(rd_n), 64'(r0));
    endtask

    task automatic t_read_select();
        int d0 = data_wr_n, a0 = adv_n, s0 = adv_sum, r0 = rd_n, sl0 = sel_n;
        lat = 1;
        put_desc(64'h1_0000_0100, (32'd5 << 16) | 32'hA, 32'd4, 64'h200);
        reg_write(1'b1, 32'h0000_0100);
        wait_done("R11 done");
        check(first_rd_addr == 64'h1_0000_0100, "R3 desc addr", first_rd_addr, 64'h1_0000_0100);
        check(rd_n - r0 == 4, "R3 reads", 64'(rd_n - r0), 4);
        check(sel_n - sl0 == 1 && !order_bad, "R4 select", 64'(sel_n - sl0), 1);
        for (int i = 0; i < 4; i++)
            check(peek(64'h200 + 64'(i)) == 8'hA0 + 8'(i), "R5 byte", 64'(peek(64'h200 + 64'(i))), 64'(8'hA0 + 8'(i)));
        check(data_wr_n - d0 == 4, "R5 writes", 64'(data_wr_n - d0), 4);
        check(adv_n - a0 == 4 && adv_sum - s0 == 4, "R5 advance", 64'(adv_sum - s0), 4);
        check(get_be32(64'h1_0000_0100) == 0, "R7 success", 64'(get_be32(64'h1_0000_0100)), 0);
    endtask

    task automatic t_skip_clear();
        int d0 = data_wr_n, a0 = adv_n, s0 = adv_sum;
        lat = 0;
        rd_seen = 1'b0;
        put_desc(64'h300, 32'h4, 32'd2, 64'h900);
        reg_write(1'b1, 32'h0000_0300);
        wait_done("R11 done");
        check(first_rd_addr == 64'h300, "R10 cleared upper", first_rd_addr, 64'h300);
        check(data_wr_n == d0, "R6 no writes", 64'(data_wr_n - d0), 0);
        check(adv_n - a0 == 1 && adv_sum - s0 == 2, "R6 advance", 64'(adv_sum - s0), 2);
        check(get_be32(64'h300) == 0, "R7 skip status", 64'(get_be32(64'h300)), 0);
        put_desc(64'h340, 32'h2, 32'd2, 64'h210);
        reg_write(1'b1, 32'h0000_0340);
        wait_done("R11 done");
        check(peek(64'h210) == 8'hA6 && peek(64'h211) == 8'hA7, "R5 after skip",
              64'({peek(64'h210), peek(64'h211)}), 64'hA6A7);
    endtask

    task automatic t_errors();
        int d0 = data_wr_n, a0 = adv_n;
        put_desc(64'h380, (32'd7 << 16) | 32'hA, 32'd5, 64'h230);
        reg_write(1'b1, 32'h0000_0380);
        wait_done("R11 done");
        check(get_be32(64'h380) == 32'd1, "R8 overrun error", 64'(get_be32(64'h380)), 1);
        check(data_wr_n == d0 && adv_n == a0, "R8 overrun no transfer", 64'(data_wr_n - d0), 0);
        lat = 2;
        put_desc(64'h3A0, (32'd9 << 16) | 32'hA, 32'd1, 64'h238);
        reg_write(1'b1, 32'h0000_03A0);
        wait_done("R11 done");
        check(get_be32(64'h3A0) == 32'd1, "R7 invalid key error", 64'(get_be32(64'h3A0)), 1);
        check(data_wr_n == d0, "R8 invalid no writes", 64'(data_wr_n - d0), 0);
    endtask

    task automatic t_busy_ignore();
        int r0;
        lat = 2;
        put_desc(64'h3C0, (32'd7 << 16) | 32'hA, 32'd3, 64'h220);
        put_desc(64'h400, 32'h4, 32'd1, 64'h0);
        r0 = rd_n;
        reg_write(1'b1, 32'h0000_03C0);
        repeat (2) @(negedge clk);
        reg_write(1'b1, 32'h0000_0400);
        reg_write(1'b0, 32'h0000_0005);
        wait_done("R11 done");
        repeat (10) @(negedge clk);
        check(!busy, "R9 no restart", 64'(busy), 0);
        check(rd_n - r0 == 4, "R9 reads", 64'(rd_n - r0), 4);
        for (int i = 0; i < 3; i++)
            check(peek(64'h220 + 64'(i)) == 8'h70 + 8'(i), "R5 key7 byte", 64'(peek(64'h220 + 64'(i))), 64'(8'h70 + 8'(i)));
        rd_seen = 1'b0;
        put_desc(64'h440, 32'h2, 32'd0, 64'h240);
        r0 = data_wr_n;
        reg_write(1'b1, 32'h0000_0440);
        wait_done("R11 done");
        check(first_rd_addr == 64'h440, "R9 upper write ignored", first_rd_addr, 64'h440);
        check(data_wr_n == r0 && get_be32(64'h440) == 0, "R5 zero length", 64'(data_wr_n - r0), 0);
        check(hold_viol == 0, "R12 handshake hold", 64'(hold_viol), 0);
        check(busy_viol == 0, "R11 busy window", 64'(busy_viol), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_upper_only();
        t_read_select();
        t_skip_clear();
        t_errors();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule